// File: doc/BRIEF.md
# Eight-Operation Single-Cycle 32-bit Core

This block is a compact single-cycle processor core for control tasks that need only a little arithmetic and memory traffic. Every clock cycle it fetches one 32-bit instruction word from a read-only instruction port and decodes it. It then runs the ALU, reads or writes one data-memory word when the instruction needs it, writes back at most one register, and selects the next program counter. There is no pipeline, so one instruction retires per cycle.

Both memories are addressed in words, so the program counter moves by one per instruction. Relative control transfers add a sign-extended offset to the incremented program counter. The data-memory port has the memory write the word at the clock edge. Read data must come back combinationally in the same cycle, so a load completes in one cycle. A self-jump (offset -1) parks the core at a fixed address and is the way a program halts.

The register file holds 32 words. Register zero is wired to zero. Opcodes and function codes outside the defined set retire as no-ops.

Top module: `mini_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. The first instruction after release is fetched from address 0.
- R2: Opcode 0x00 with funct 0x20 writes rs+rt, and funct 0x22 writes rs-rt, into register rd. Both use 32-bit two's-complement arithmetic that wraps on overflow. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0].
- R3: Opcode 0x00 with funct 0x24 writes the bitwise AND of rs and rt into rd, and funct 0x25 writes their bitwise OR.
- R4: Opcode 0x23 (load) writes the data-memory word at address rs + sign-extended imm[15:0] into register rt.
- R5: Opcode 0x2B (store) drives `dmem_addr` = rs + sign-extended imm[15:0] and `dmem_wdata` = register rt. It raises `dmem_we` for exactly that instruction's cycle. No other instruction raises `dmem_we`.
- R6: Opcode 0x04 (branch-if-equal) sets the next PC to PC+1+sign-extended imm[15:0] when rs equals rt, and to PC+1 otherwise. Both forward and zero-register comparisons follow this rule.
- R7: Opcode 0x02 (jump) always sets the next PC to PC+1 plus the sign-extended 26-bit offset in bits [25:0]. Negative offsets jump backwards, and offset -1 holds the PC in place.
- R8: Register 0 reads as zero in every operand position. Loads and ALU results aimed at it are discarded.
- R9: An undefined opcode, or opcode 0x00 with an undefined funct, changes no register and no memory word and does not raise `dmem_we`.
- R10: Every instruction other than a taken branch or a jump, including an undefined one, advances the PC by exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| imem_addr | output | PC_W (16) | Word address of the instruction being executed |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | DA_W (16) | Data-memory word address for load or store |
| dmem_wdata | output | XLEN (32) | Word to write on a store |
| dmem_we | output | 1 | Write strobe, sampled by the memory at the rising clock edge |
| dmem_rdata | input | XLEN (32) | Word at `dmem_addr`, combinational |

## Verification
The assertions on the PC sequence assume that `imem_data` is always a known word. They also assume that the register operands of any branch were written before the branch, since the register file has no reset and its unwritten entries are undefined. The stimulus clears both bench memories while reset is held. It fills unused instruction slots with self-jumps and loads every register from data memory before any instruction reads it. It also keeps all load and store addresses inside the 64-word bench memory.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR
  } alu_op_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef struct packed {
    alu_op_e alu_op;
    logic    use_imm;
    logic    dst_rt;
    logic    reg_we;
    logic    load;
    logic    store;
    logic    branch;
    logic    jump;
    logic    illegal;
  } ctrl_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          default: begin
            ctrl.reg_we  = 1'b0;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      OP_LOAD: begin
        ctrl.use_imm = 1'b1;
        ctrl.dst_rt  = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.load    = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.store   = 1'b1;
      end
      OP_BEQ:   ctrl.branch  = 1'b1;
      OP_JUMP:  ctrl.jump    = 1'b1;
      default:  ctrl.illegal = 1'b1;
    endcase
  end

  // R9: an undefined encoding must leave every side effect off
  always_comb begin
    a_r9_undef_quiet: assert (!ctrl.illegal ||
                              !(ctrl.reg_we || ctrl.store || ctrl.branch || ctrl.jump));
    a_r5_store_no_writeback: assert (!(ctrl.store && (ctrl.reg_we || ctrl.load)));
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = a | b;
    endcase
  end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs_q [N];

  // entry 0 is never written; its reads are forced to zero below
  always_ff @(posedge clk) begin
    for (int i = 1; i < N; i++) begin
      if (we && (waddr == AW'(i))) regs_q[i] <= wdata;
    end
  end

  assign rdata_a = (ra == '0) ? '0 : regs_q[ra];
  assign rdata_b = (rb == '0) ? '0 : regs_q[rb];

endmodule

// File: rtl/mini_core.sv
module mini_core
  import mc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int PC_W  = 16,
  parameter int DA_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [DA_W-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int RA_W = $clog2(NREGS);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  // instruction fields
  logic [RA_W-1:0] rs, rt, rd;
  logic [15:0]     imm16;
  logic [25:0]     off26;
  assign rs    = imem_data[21 +: RA_W];
  assign rt    = imem_data[16 +: RA_W];
  assign rd    = imem_data[11 +: RA_W];
  assign imm16 = imem_data[15:0];
  assign off26 = imem_data[25:0];

  ctrl_t ctrl;
  mc_decode u_dec (
    .opcode (imem_data[31:26]),
    .funct  (imem_data[5:0]),
    .ctrl   (ctrl)
  );

  // register file
  logic [XLEN-1:0] rs_val, rt_val, wb_val;
  logic [RA_W-1:0] wb_addr;
  mc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk     (clk),
    .we      (ctrl.reg_we),
    .waddr   (wb_addr),
    .wdata   (wb_val),
    .ra      (rs),
    .rb      (rt),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  // operand selection and ALU
  logic [XLEN-1:0] imm_x, alu_b, alu_y;
  assign imm_x = {{(XLEN-16){imm16[15]}}, imm16};
  assign alu_b = ctrl.use_imm ? imm_x : rt_val;

  mc_alu #(.W(XLEN)) u_alu (
    .a  (rs_val),
    .b  (alu_b),
    .op (ctrl.alu_op),
    .y  (alu_y)
  );

  assign wb_addr = ctrl.dst_rt ? rt : rd;
  assign wb_val  = ctrl.load ? dmem_rdata : alu_y;

  // data memory port; no stores while reset is held
  assign dmem_addr  = alu_y[DA_W-1:0];
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.store & rst_n;

  // program counter: next-state logic
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, br_off, j_off;
  logic [31:0]     off_x;
  logic            taken;

  assign off_x  = {{6{off26[25]}}, off26};
  assign br_off = imm_x[PC_W-1:0];
  assign j_off  = off_x[PC_W-1:0];
  assign pc_inc = pc_q + PC_ONE;
  assign taken  = ctrl.branch && (rs_val == rt_val);

  always_comb begin
    if (ctrl.jump)  pc_d = pc_inc + j_off;
    else if (taken) pc_d = pc_inc + br_off;
    else            pc_d = pc_inc;
  end

  // program counter: register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign imem_addr = pc_q;

  // R10: sequential flow advances by exactly one word
  a_r10_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.jump && !ctrl.branch) |=> (pc_q == $past(pc_q) + PC_ONE));

  // R6: an unequal compare falls through
  a_r6_branch_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.branch && (rs_val != rt_val)) |=> (pc_q == $past(pc_q) + PC_ONE));

  // R7: a jump with offset -1 parks the PC
  a_r7_self_jump_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.jump && (off26 == '1)) |=> $stable(pc_q));

  // R8: register zero yields zero on both read ports
  a_r8_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    ((rs == '0) |-> (rs_val == '0)) and ((rt == '0) |-> (rt_val == '0)));

  // R1: no write strobe while reset is asserted
  a_r1_no_store_in_reset: assert property (@(posedge clk)
    !rst_n |-> !dmem_we);

endmodule

// File: tb/sim_mini_core.sv
module sim_mini_core;

  localparam logic [31:0] SENT = 32'h5A5A_5A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr;
  logic [31:0] imem_data;
  logic [15:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic        dmem_we;
  logic [31:0] dmem_rdata;

  logic [31:0] prog [64];
  logic [31:0] dmem [64];
  logic        pl_en = 1'b0;
  logic [5:0]  pl_addr = '0;
  logic [31:0] pl_data = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  mini_core u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_data  = prog[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) begin
    if (pl_en)        dmem[pl_addr] <= pl_data;
    else if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
  end

  // encoders
  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
    return {6'h00, s[4:0], t[4:0], d[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    return {op, s[4:0], t[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int off);
    return {6'h02, off[25:0]};
  endfunction
  function automatic logic [31:0] ld(int t, int imm, int s);
    return enc_i(6'h23, s, t, imm);
  endfunction
  function automatic logic [31:0] st(int t, int imm, int s);
    return enc_i(6'h2B, s, t, imm);
  endfunction
  function automatic logic [31:0] beq(int s, int t, int imm);
    return enc_i(6'h04, s, t, imm);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pl(int a, logic [31:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a[5:0]; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  // hold reset, clear memories, fill program slots with self-jumps
  task automatic begin_test();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) prog[i] = enc_j(-1);
    for (int i = 0; i < 64; i++) pl(i, SENT);
  endtask

  task automatic release_reset();
    @(negedge clk);
    chk("R1 reset pc", 32'(imem_addr), 32'd0);
    chk("R1 reset we", 32'(dmem_we), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic wait_pc(int pc);
    for (int i = 0; i < 80; i++) begin
      if (imem_addr == 16'(pc)) return;
      @(negedge clk);
    end
  endtask

  task automatic run_halt(string req, int halt_pc);
    repeat (60) @(negedge clk);
    chk(req, 32'(imem_addr), 32'(halt_pc));
  endtask

  task automatic t_arith();
    begin_test();
    pl(0, 32'h7FFF_FFFF); pl(1, 32'd1); pl(2, 32'hFFFF_FFFB); pl(3, 32'd3);
    prog[0] = ld(1, 0, 0); prog[1] = ld(2, 1, 0);
    prog[2] = ld(3, 2, 0); prog[3] = ld(4, 3, 0);
    prog[4] = enc_r(1, 2, 5, 6'h20); prog[5] = st(5, 32, 0);
    prog[6] = enc_r(3, 4, 6, 6'h22); prog[7] = st(6, 33, 0);
    prog[8] = enc_r(4, 3, 7, 6'h22); prog[9] = st(7, 34, 0);
    release_reset();
    run_halt("R10 arith halt", 10);
    chk("R2 add wraps", dmem[32], 32'h8000_0000);
    chk("R2 sub negative", dmem[33], 32'hFFFF_FFF8);
    chk("R2 sub of negative", dmem[34], 32'd8);
  endtask

  task automatic t_logic();
    begin_test();
    pl(4, 32'h0F0F_00FF); pl(5, 32'h00FF_0F0F);
    prog[0] = ld(1, 4, 0); prog[1] = ld(2, 5, 0);
    prog[2] = enc_r(1, 2, 3, 6'h24); prog[3] = st(3, 36, 0);
    prog[4] = enc_r(1, 2, 4, 6'h25); prog[5] = st(4, 37, 0);
    prog[6] = enc_r(1, 0, 5, 6'h24); prog[7] = st(5, 38, 0);
    release_reset();
    run_halt("R10 logic halt", 8);
    chk("R3 and", dmem[36], 32'h000F_000F);
    chk("R3 or", dmem[37], 32'h0FFF_0FFF);
    chk("R3 and with r0", dmem[38], 32'h0);
  endtask

  task automatic t_mem();
    begin_test();
    pl(6, 32'd40); pl(30, 32'h1234_5678);
    prog[0] = ld(1, 6, 0); prog[1] = ld(2, -10, 1); prog[2] = st(2, 5, 1);
    release_reset();
    wait_pc(1);
    chk("R4 load address", 32'(dmem_addr), 32'd30);
    chk("R5 no strobe on load", 32'(dmem_we), 32'd0);
    @(negedge clk);
    chk("R5 store strobe", 32'(dmem_we), 32'd1);
    chk("R5 store address", 32'(dmem_addr), 32'd45);
    chk("R5 store data", dmem_wdata, 32'h1234_5678);
    @(negedge clk);
    chk("R5 strobe drops", 32'(dmem_we), 32'd0);
    run_halt("R10 mem halt", 3);
    chk("R4 loaded value stored", dmem[45], 32'h1234_5678);
  endtask

  task automatic t_zero();
    begin_test();
    pl(7, 32'hDEAD_BEEF);
    prog[0] = ld(0, 7, 0); prog[1] = st(0, 46, 0);
    prog[2] = ld(1, 7, 0); prog[3] = enc_r(1, 1, 0, 6'h20);
    prog[4] = st(0, 47, 0); prog[5] = enc_r(1, 0, 0, 6'h25);
    prog[6] = st(0, 48, 0);
    release_reset();
    run_halt("R10 zero halt", 7);
    chk("R8 load to r0 dropped", dmem[46], 32'h0);
    chk("R8 add to r0 dropped", dmem[47], 32'h0);
    chk("R8 or to r0 dropped", dmem[48], 32'h0);
  endtask

  task automatic t_branch();
    begin_test();
    pl(1, 32'd1); pl(3, 32'd3);
    prog[0] = ld(1, 1, 0); prog[1] = ld(2, 1, 0); prog[2] = ld(3, 3, 0);
    prog[3] = beq(1, 2, 1);  prog[4] = st(3, 50, 0); prog[5] = st(1, 51, 0);
    prog[6] = beq(1, 3, 1);  prog[7] = st(3, 52, 0);
    prog[8] = beq(0, 0, 1);  prog[9] = st(3, 53, 0);
    release_reset();
    wait_pc(3);
    @(negedge clk);
    chk("R6 taken target", 32'(imem_addr), 32'd5);
    run_halt("R6 branch halt", 10);
    chk("R6 taken skips", dmem[50], SENT);
    chk("R6 after taken", dmem[51], 32'd1);
    chk("R6 not taken runs", dmem[52], 32'd3);
    chk("R6 r0 equal skips", dmem[53], SENT);
  endtask

  task automatic t_jump();
    begin_test();
    pl(3, 32'd3);
    prog[0] = ld(1, 3, 0); prog[1] = enc_j(2);
    prog[2] = st(1, 54, 0); prog[3] = st(1, 55, 0); prog[4] = st(1, 56, 0);
    prog[5] = enc_j(2); prog[6] = st(1, 57, 0); prog[7] = enc_j(-1);
    prog[8] = enc_j(-3);
    release_reset();
    run_halt("R7 jump halt", 7);
    chk("R7 forward skip a", dmem[54], SENT);
    chk("R7 forward skip b", dmem[55], SENT);
    chk("R7 forward landing", dmem[56], 32'd3);
    chk("R7 backward landing", dmem[57], 32'd3);
  endtask

  task automatic t_undef();
    begin_test();
    pl(3, 32'd3); pl(5, 32'd9);
    prog[0] = ld(1, 3, 0);
    prog[1] = enc_i(6'h3F, 0, 1, 5);
    prog[2] = enc_r(1, 1, 1, 6'h3F);
    prog[3] = enc_i(6'h2A, 0, 1, 5);
    prog[4] = st(1, 58, 0);
    release_reset();
    wait_pc(1);
    chk("R9 undefined op no strobe", 32'(dmem_we), 32'd0);
    @(negedge clk);
    chk("R10 undefined op advances", 32'(imem_addr), 32'd2);
    chk("R9 undefined funct no strobe", 32'(dmem_we), 32'd0);
    run_halt("R10 undef halt", 5);
    chk("R9 register unchanged", dmem[58], 32'd3);
    chk("R9 memory untouched", dmem[5], 32'd9);
  endtask

  initial begin
    t_arith();
    t_logic();
    t_mem();
    t_zero();
    t_branch();
    t_jump();
    t_undef();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule